// File: doc/BRIEF.md
# Hash Offload Register Interface

This block is the software-facing front end of a hash offload engine. A processor programs a source address, a destination address and a source length over a 32-bit register bus. It then writes a command word. That write both stores the command and, when the algorithm field decodes to a supported digest, launches a job. The job request goes to a separate digest engine as a one-cycle start pulse, together with a compact algorithm code and the source, destination and length values.

The digest engine reports the end of the job with a one-cycle done pulse. The block then records completion in a status bit and, if the command asked for it, raises an interrupt. Software acknowledges completion by writing 1 to the status bit. Command fields for features the engine does not provide (keyed-hash modes, descriptor lists, chained cipher operation) are accepted but raise a sticky flag. A command written while a job is still running is discarded and raises a second sticky flag.

Top module: `hash_regif`

## Requirements
- R1: After reset, every register reads 0, and job_start_o, irq_o, unsup_o and cmd_drop_o are 0.
- R2: On write, the source address (byte 0x20) keeps bits [30:0]. The destination address (byte 0x24) keeps bits [30:3], so bits [2:0] read 0. The length (byte 0x2C) keeps bits [27:0]. job_src_o, job_dst_o and job_len_o always present these masked values.
- R3: A read at byte address 0x64 or above returns 0. A write there changes no register, including words whose low index bits would alias it. bus_rdata_o is 0 whenever bus_re_i is low.
- R4: A write to the command word (byte 0x30) is stored as written. If the algorithm decodes as valid and no job is busy, job_start_o is high for exactly the one cycle that follows the write edge.
- R5: Command bits [6:4] map to job_alg_o as follows: 000 gives 0 (MD5), 010 gives 1 (SHA-1), 100 gives 2 (SHA-224), 101 gives 3 (SHA-256). The codes 001, 011 and 111 are invalid and start no job.
- R6: With bits [6:4] = 110, command bits [12:10] map as follows: 000 gives 5 (SHA-512), 001 gives 4 (SHA-384), 010 gives 3, 011 gives 2. The codes 100 to 111 are invalid and start no job.
- R7: A done pulse while busy sets status bit 9 (byte 0x1C) whatever the value of command bit 9. irq_o rises on that edge only if the stored command bit 9 is 1.
- R8: A status write with bit 9 = 1 clears status bit 9 and irq_o. A status write never sets bit 9. A done pulse on the same edge as a clear wins.
- R9: An accepted command with a nonzero bits [8:7], bit 18 = 1 or bit 1 = 1 sets unsup_o. The flag stays set until reset, and a valid job still starts.
- R10: Status bit 0 reads 1 while a job is busy and clears on the done pulse. A done pulse while idle changes nothing. A command write while busy is neither stored nor started, and sets the sticky cmd_drop_o.
- R11: Every other word inside the window (for example byte 0x10) stores the full 32-bit written value and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_re_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address; bits [1:0] ignored for word selection |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| job_start_o | output | 1 | One-cycle job launch pulse |
| job_alg_o | output | 3 | Algorithm code of the launched job |
| job_src_o | output | 32 | Masked source address |
| job_dst_o | output | 32 | Masked destination address |
| job_len_o | output | 32 | Masked source length |
| job_done_i | input | 1 | Job completion pulse from the digest engine |
| irq_o | output | 1 | Completion interrupt |
| unsup_o | output | 1 | Sticky unsupported-command flag |
| cmd_drop_o | output | 1 | Sticky flag: command written while busy |

## Verification
Read data depends only on the current address and the register state, so a read strobe driven in one cycle is due before the next edge. Every write and done pulse takes effect on the single edge that samples it. job_start_o, busy, status bit 9, irq_o and both sticky flags are all visible in the cycle right after that edge, and job_start_o falls one edge later. The bench drives inputs one nanosecond after the falling edge. It advances a behavioural model on each rising edge and compares every output against it on the following falling edge, so each result is checked in exactly the cycle it becomes due. Directed checks sample at that same point after each stimulus task returns.

// File: rtl/hash_regif_pkg.sv
package hash_regif_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hash_alg_e;

  // word indices (byte offset / 4)
  localparam int unsigned W_STATUS = 7;
  localparam int unsigned W_SRC    = 8;
  localparam int unsigned W_DST    = 9;
  localparam int unsigned W_LEN    = 11;
  localparam int unsigned W_CMD    = 12;

  localparam int unsigned ST_BUSY_BIT = 0;
  localparam int unsigned ST_DONE_BIT = 9;
  localparam int unsigned CMD_IEN_BIT = 9;

  function automatic logic is_special(int unsigned idx);
    return (idx == W_STATUS) || (idx == W_SRC) || (idx == W_DST) ||
           (idx == W_LEN) || (idx == W_CMD);
  endfunction

endpackage

// File: rtl/hash_algo_dec.sv
module hash_algo_dec
  import hash_regif_pkg::*;
(
  input  logic [2:0] main_sel_i,
  input  logic [2:0] wide_sel_i,
  input  logic [1:0] keyed_i,
  input  logic       list_en_i,
  input  logic       chain_i,
  output logic       valid_o,
  output hash_alg_e  alg_o,
  output logic       unsup_o
);

  always_comb begin
    valid_o = 1'b1;
    alg_o   = ALG_MD5;
    unique case (main_sel_i)
      3'b000: alg_o = ALG_MD5;
      3'b010: alg_o = ALG_SHA1;
      3'b100: alg_o = ALG_SHA224;
      3'b101: alg_o = ALG_SHA256;
      3'b110: begin
        unique case (wide_sel_i)
          3'b000:  alg_o = ALG_SHA512;
          3'b001:  alg_o = ALG_SHA384;
          3'b010:  alg_o = ALG_SHA256;
          3'b011:  alg_o = ALG_SHA224;
          default: valid_o = 1'b0;
        endcase
      end
      default: valid_o = 1'b0;
    endcase
  end

  assign unsup_o = (|keyed_i) | list_en_i | chain_i;

endmodule

// File: rtl/hash_job_ctrl.sv
module hash_job_ctrl
  import hash_regif_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_wr_i,
  input  logic      alg_valid_i,
  input  hash_alg_e alg_i,
  input  logic      unsup_i,
  input  logic      irq_en_i,
  input  logic      st_clr_i,
  input  logic      done_i,
  output logic      cmd_accept_o,
  output logic      busy_o,
  output logic      st_done_o,
  output logic      start_o,
  output hash_alg_e alg_o,
  output logic      irq_o,
  output logic      unsup_o,
  output logic      drop_o
);

  logic      busy_q, st_done_q, start_q, irq_q, unsup_q, drop_q;
  hash_alg_e alg_q;

  assign cmd_accept_o = cmd_wr_i & ~busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      st_done_q <= 1'b0;
      start_q   <= 1'b0;
      irq_q     <= 1'b0;
      unsup_q   <= 1'b0;
      drop_q    <= 1'b0;
      alg_q     <= ALG_MD5;
    end else begin
      start_q <= 1'b0;
      // completion beats an acknowledge on the same edge
      if (done_i && busy_q) begin
        busy_q    <= 1'b0;
        st_done_q <= 1'b1;
        if (irq_en_i) irq_q <= 1'b1;
      end else if (st_clr_i) begin
        st_done_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      if (cmd_wr_i) begin
        if (busy_q) begin
          drop_q <= 1'b1;
        end else begin
          if (unsup_i) unsup_q <= 1'b1;
          if (alg_valid_i) begin
            start_q <= 1'b1;
            busy_q  <= 1'b1;
            alg_q   <= alg_i;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign st_done_o = st_done_q;
  assign start_o   = start_q;
  assign alg_o     = alg_q;
  assign irq_o     = irq_q;
  assign unsup_o   = unsup_q;
  assign drop_o    = drop_q;

endmodule

// File: rtl/hash_word_store.sv
module hash_word_store
  import hash_regif_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 25,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] words [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    if (is_special(i)) begin : g_hole
      assign words[i] = '0;
    end else begin : g_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                              words[i] <= '0;
        else if (we_i && idx_i == IDX_W'(i))      words[i] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx_i == IDX_W'(i)) rdata_o = words[i];
    end
  end

endmodule

// File: rtl/hash_regif.sv
module hash_regif
  import hash_regif_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 12,
  parameter int unsigned       NUM_WORDS = 25,
  parameter logic [31:0]       SRC_MASK  = 32'h7FFF_FFFF,
  parameter logic [31:0]       DST_MASK  = 32'h7FFF_FFF8,
  parameter logic [31:0]       LEN_MASK  = 32'h0FFF_FFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              job_start_o,
  output logic [2:0]        job_alg_o,
  output logic [31:0]       job_src_o,
  output logic [31:0]       job_dst_o,
  output logic [31:0]       job_len_o,
  input  logic              job_done_i,
  output logic              irq_o,
  output logic              unsup_o,
  output logic              cmd_drop_o
);

  localparam int unsigned IDX_W     = ADDR_W - 2;
  localparam int unsigned WIN_BYTES = NUM_WORDS * 4;

  logic [IDX_W-1:0] widx;
  logic             in_win, wr_ok;
  logic             sel_st, sel_src, sel_dst, sel_len, sel_cmd, sel_gen;

  assign widx    = bus_addr_i[ADDR_W-1:2];
  assign in_win  = bus_addr_i < ADDR_W'(WIN_BYTES);
  assign wr_ok   = bus_we_i & in_win;
  assign sel_st  = widx == IDX_W'(W_STATUS);
  assign sel_src = widx == IDX_W'(W_SRC);
  assign sel_dst = widx == IDX_W'(W_DST);
  assign sel_len = widx == IDX_W'(W_LEN);
  assign sel_cmd = widx == IDX_W'(W_CMD);
  assign sel_gen = ~(sel_st | sel_src | sel_dst | sel_len | sel_cmd);

  logic [31:0] src_q, dst_q, len_q, cmd_q;
  logic        cmd_accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
      cmd_q <= '0;
    end else if (wr_ok) begin
      if (sel_src)                src_q <= bus_wdata_i & SRC_MASK;
      if (sel_dst)                dst_q <= bus_wdata_i & DST_MASK;
      if (sel_len)                len_q <= bus_wdata_i & LEN_MASK;
      if (sel_cmd && cmd_accept)  cmd_q <= bus_wdata_i;
    end
  end

  logic      alg_valid, cmd_unsup;
  hash_alg_e dec_alg, job_alg;

  hash_algo_dec i_dec (
    .main_sel_i (bus_wdata_i[6:4]),
    .wide_sel_i (bus_wdata_i[12:10]),
    .keyed_i    (bus_wdata_i[8:7]),
    .list_en_i  (bus_wdata_i[18]),
    .chain_i    (bus_wdata_i[1]),
    .valid_o    (alg_valid),
    .alg_o      (dec_alg),
    .unsup_o    (cmd_unsup)
  );

  logic busy, st_done;

  hash_job_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (wr_ok & sel_cmd),
    .alg_valid_i  (alg_valid),
    .alg_i        (dec_alg),
    .unsup_i      (cmd_unsup),
    .irq_en_i     (cmd_q[CMD_IEN_BIT]),
    .st_clr_i     (wr_ok & sel_st & bus_wdata_i[ST_DONE_BIT]),
    .done_i       (job_done_i),
    .cmd_accept_o (cmd_accept),
    .busy_o       (busy),
    .st_done_o    (st_done),
    .start_o      (job_start_o),
    .alg_o        (job_alg),
    .irq_o        (irq_o),
    .unsup_o      (unsup_o),
    .drop_o       (cmd_drop_o)
  );

  logic [31:0] gen_rdata;

  hash_word_store #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .DATA_W    (32)
  ) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_ok & sel_gen),
    .idx_i   (widx),
    .wdata_i (bus_wdata_i),
    .rdata_o (gen_rdata)
  );

  logic [31:0] status_word;

  always_comb begin
    status_word              = '0;
    status_word[ST_BUSY_BIT] = busy;
    status_word[ST_DONE_BIT] = st_done;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_re_i && in_win) begin
      if      (sel_st)  bus_rdata_o = status_word;
      else if (sel_src) bus_rdata_o = src_q;
      else if (sel_dst) bus_rdata_o = dst_q;
      else if (sel_len) bus_rdata_o = len_q;
      else if (sel_cmd) bus_rdata_o = cmd_q;
      else              bus_rdata_o = gen_rdata;
    end
  end

  assign job_alg_o = job_alg;
  assign job_src_o = src_q;
  assign job_dst_o = dst_q;
  assign job_len_o = len_q;

endmodule

// File: rtl/hash_regif_chk.sv
module hash_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        job_start_o,
  input logic        job_done_i,
  input logic [31:0] job_dst_o,
  input logic        irq_o,
  input logic        unsup_o,
  input logic        cmd_drop_o,
  input logic        busy_i,
  input logic        st_done_i
);

  // R4: launch is a single-cycle pulse
  p_start_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_o |=> !job_start_o);

  // R10: a launch leaves the engine busy, and only from idle
  p_start_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_start_o |-> busy_i && !$past(busy_i));

  // R10: done while busy frees the engine and records completion (R7)
  p_done_frees_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (job_done_i && busy_i) |=> !busy_i && st_done_i);

  // R7: interrupt never without completion status
  p_irq_needs_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> st_done_i);

  // R9: unsupported flag is sticky
  p_unsup_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |=> unsup_o);

  // R10: drop flag is sticky
  p_drop_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_drop_o |=> cmd_drop_o);

  // R2: destination stays 8-byte aligned
  p_dst_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    job_dst_o[2:0] == 3'b000);

endmodule

bind hash_regif hash_regif_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .job_start_o (job_start_o),
  .job_done_i  (job_done_i),
  .job_dst_o   (job_dst_o),
  .irq_o       (irq_o),
  .unsup_o     (unsup_o),
  .cmd_drop_o  (cmd_drop_o),
  .busy_i      (busy),
  .st_done_i   (st_done)
);

// File: tb/test_hash_regif.sv
`timescale 1ns/1ps
module test_hash_regif;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0, done = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, src, dst, len;
  logic        start, irq, unsup, drop;
  logic [2:0]  alg;

  always #2 clk = ~clk;

  hash_regif i_hash_regif (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .job_start_o(start), .job_alg_o(alg), .job_src_o(src),
    .job_dst_o(dst), .job_len_o(len), .job_done_i(done),
    .irq_o(irq), .unsup_o(unsup), .cmd_drop_o(drop)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_word [25];
  bit      m_busy, m_st, m_irq, m_unsup, m_drop, m_start;
  int      m_alg;

  function automatic int ref_alg(logic [31:0] c);
    // returns -1 when the command starts nothing
    case (c[6:4])
      3'd0: return 0;
      3'd2: return 1;
      3'd4: return 2;
      3'd5: return 3;
      3'd6: case (c[12:10])
              3'd0: return 5;
              3'd1: return 4;
              3'd2: return 3;
              3'd3: return 2;
              default: return -1;
            endcase
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] ref_read(logic r, logic [11:0] a);
    int w;
    if (!r || a >= 12'h64) return 32'h0;
    w = int'(a) / 4;
    if (w == 7) return (32'(m_st) << 9) | 32'(m_busy);
    return m_word[w];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_word[i]) m_word[i] = 0;
      m_busy = 0; m_st = 0; m_irq = 0; m_unsup = 0; m_drop = 0;
      m_start = 0; m_alg = 0;
    end else begin
      bit was_busy, irq_en, fin;
      was_busy = m_busy;
      irq_en   = m_word[12][9];
      m_start  = 0;
      fin      = done && was_busy;
      if (fin) begin
        m_busy = 0; m_st = 1;
        if (irq_en) m_irq = 1;
      end
      if (we && addr < 12'h64) begin
        case (int'(addr) / 4)
          7:  if (wdata[9] && !fin) begin m_st = 0; m_irq = 0; end
          8:  m_word[8]  = wdata & 32'h7FFF_FFFF;
          9:  m_word[9]  = wdata & 32'h7FFF_FFF8;
          11: m_word[11] = wdata & 32'h0FFF_FFFF;
          12: begin
            if (was_busy) m_drop = 1;
            else begin
              m_word[12] = wdata;
              if (wdata[8:7] != 0 || wdata[18] || wdata[1]) m_unsup = 1;
              if (ref_alg(wdata) >= 0) begin
                m_start = 1; m_busy = 1; m_alg = ref_alg(wdata);
              end
            end
          end
          default: m_word[int'(addr) / 4] = wdata;
        endcase
      end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1/R3/R11 rdata", rdata, ref_read(re, addr));
      chk("R4 job_start_o", 32'(start), 32'(m_start));
      chk("R5/R6 job_alg_o", 32'(alg), 32'(m_alg));
      chk("R2 job_src_o", src, m_word[8]);
      chk("R2 job_dst_o", dst, m_word[9]);
      chk("R2 job_len_o", len, m_word[11]);
      chk("R7 irq_o", 32'(irq), 32'(m_irq));
      chk("R9 unsup_o", 32'(unsup), 32'(m_unsup));
      chk("R10 cmd_drop_o", 32'(drop), 32'(m_drop));
    end
  end

  // ---------------- stimulus helpers (called at negedge+1) ----------------
  task automatic wr(logic [11:0] a, logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    we = 0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    re = 1; addr = a;
    @(negedge clk);
    chk(tag, rdata, exp);
    #1; re = 0;
  endtask

  task automatic pulse_done();
    done = 1;
    @(negedge clk); #1;
    done = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1;
    @(negedge clk); #1;

    // R1 reset state
    chk("R1 start", 32'(start), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 unsup", 32'(unsup), 0);
    chk("R1 drop", 32'(drop), 0);
    rd(12'h1C, 0, "R1 status");
    rd(12'h30, 0, "R1 cmd");
    rd(12'h10, 0, "R1 cipher word");

    // R2 masks
    wr(12'h20, 32'hFFFF_FFFF);
    wr(12'h24, 32'hFFFF_FFFF);
    wr(12'h2C, 32'hFFFF_FFFF);
    rd(12'h20, 32'h7FFF_FFFF, "R2 src mask");
    rd(12'h24, 32'h7FFF_FFF8, "R2 dst mask");
    rd(12'h2C, 32'h0FFF_FFFF, "R2 len mask");
    chk("R2 dst port", dst, 32'h7FFF_FFF8);

    // R11 generic words
    wr(12'h10, 32'hA5A5_0001);
    wr(12'h00, 32'h0000_1234);
    wr(12'h60, 32'hCAFE_F00D);
    rd(12'h10, 32'hA5A5_0001, "R11 word 0x10");
    rd(12'h60, 32'hCAFE_F00D, "R11 last word");

    // R3 outside window
    wr(12'h080, 32'hDEAD_BEEF);
    wr(12'h064, 32'hDEAD_BEEF);
    rd(12'h000, 32'h0000_1234, "R3 no alias");
    rd(12'h080, 0, "R3 read out");
    rd(12'h064, 0, "R3 read edge");
    addr = 12'h10; @(negedge clk); chk("R3 no re", rdata, 0); #1;

    // R4/R7 MD5 with interrupt enabled
    wr(12'h30, 32'h0000_0200);
    chk("R4 start pulse", 32'(start), 1);
    chk("R5 md5 code", 32'(alg), 0);
    rd(12'h1C, 32'h1, "R10 busy bit");
    chk("R4 start fell", 32'(start), 0);
    rd(12'h30, 32'h0000_0200, "R4 cmd stored");
    // R10 write while busy
    wr(12'h30, 32'h0000_0020);
    chk("R10 no start while busy", 32'(start), 0);
    chk("R10 drop flag", 32'(drop), 1);
    rd(12'h30, 32'h0000_0200, "R10 cmd kept");
    pulse_done();
    chk("R7 irq raised", 32'(irq), 1);
    rd(12'h1C, 32'h200, "R7 status done");
    wr(12'h1C, 32'h0000_0000);
    rd(12'h1C, 32'h200, "R8 zero write keeps bit");
    wr(12'h1C, 32'h0000_0200);
    rd(12'h1C, 0, "R8 cleared");
    chk("R8 irq cleared", 32'(irq), 0);
    wr(12'h1C, 32'hFFFF_FFFF);
    rd(12'h1C, 0, "R8 never sets");

    // R7 completion without enable
    wr(12'h30, 32'h0000_0020);
    chk("R5 sha1 code", 32'(alg), 1);
    pulse_done();
    chk("R7 no irq", 32'(irq), 0);
    rd(12'h1C, 32'h200, "R7 status w/o enable");
    wr(12'h1C, 32'h200);

    // R10 done while idle
    pulse_done();
    rd(12'h1C, 0, "R10 idle done ignored");

    // R5 main field sweep
    for (int c = 0; c < 8; c++) begin
      wr(12'h30, 32'(c) << 4);
      chk("R5 start per code", 32'(start), (ref_alg(32'(c) << 4) >= 0) ? 1 : 0);
      if (start) begin
        chk("R5 alg per code", 32'(alg), 32'(ref_alg(32'(c) << 4)));
        pulse_done();
      end
      wr(12'h1C, 32'h200);
    end

    // R6 wide family sweep
    for (int s = 0; s < 8; s++) begin
      wr(12'h30, 32'h60 | (32'(s) << 10));
      chk("R6 start per sub", 32'(start), (s < 4) ? 1 : 0);
      if (start) begin
        chk("R6 alg per sub", 32'(alg), 32'(ref_alg(32'h60 | (32'(s) << 10))));
        pulse_done();
      end
      wr(12'h1C, 32'h200);
    end

    // R8 done and clear on the same edge
    wr(12'h30, 32'h0000_0250);
    we = 1; addr = 12'h1C; wdata = 32'h200; done = 1;
    @(negedge clk); #1;
    we = 0; done = 0;
    rd(12'h1C, 32'h200, "R8 done wins");
    chk("R8 irq kept", 32'(irq), 1);
    wr(12'h1C, 32'h200);

    // R9 unsupported fields
    chk("R9 flag low", 32'(unsup), 0);
    wr(12'h30, 32'h0004_0050);
    chk("R9 flag set", 32'(unsup), 1);
    chk("R9 job still starts", 32'(start), 1);
    pulse_done();
    wr(12'h1C, 32'h200);
    wr(12'h30, 32'h0000_0182);
    idle(2);
    chk("R9 sticky", 32'(unsup), 1);

    idle(2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule